// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is a memory-mapped character transmitter that sits on a 16-bit register bus. Software sees two word addresses: a control/status register and a transmit data buffer. A byte written to the data buffer goes into a one-byte holding register. When the shift register is idle, the holding register passes its byte to the shift register on the next clock. This frees the holding register again, so software can queue a second character while the first one is still being sent on the line.

The shift register sends each character as an asynchronous frame on a single output line. The bit period is derived from the clock frequency and one of two baud rates, which a static select input chooses. The ready flag sits in the sign bit of the status byte, so a byte test followed by a sign branch can poll it. When the interrupt enable and ready are both true, the block raises a vectored interrupt request. The request stays up until a grant arrives. The block answers the grant with an acknowledge pulse that carries the vector.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset, the ready flag is 1, the interrupt enable is 0, the holding register and the shifter are empty, the TX line is high, and no interrupt request or acknowledge is active.
- R2: A read is answered on `bus_rdata` in the cycle after `bus_rd`. A read of the status address (octal 177564) returns the ready flag in bit 7 and the enable in bit 6, with every other bit 0. A read of the data address (octal 177566) returns 0.
- R3: A status write with `bus_be[0]` set stores only `bus_wdata[6]` as the enable, so writing 0 disables interrupts. All other data bits have no effect, and a status write with `bus_be[0]` clear has no effect.
- R4: A data write with `bus_be[0]` set, made while the shifter is idle, drops ready for exactly one cycle. The shifter takes the byte on the following clock.
- R5: A data write made while the shifter is busy holds the byte and keeps ready low until the current frame ends. The held byte is then sent as the next frame.
- R6: A frame is one low start bit, then 8 data bits with the least significant bit first, then one high stop bit. The line stays high while the shifter is idle.
- R7: Each bit lasts CLK_HZ/FAST_BAUD cycles when `baud_slow` is 0 and CLK_HZ/SLOW_BAUD cycles when it is 1. The rate is sampled when a frame starts.
- R8: The interrupt request rises one cycle after ready and enable first become true together. This includes setting the enable while ready is already high. No request is raised while ready is low.
- R9: A pending request stays high until `intr_grant` arrives. The cycle after the grant, `intr_ack` pulses for one cycle with `intr_vector` equal to octal 064, and the request has dropped.
- R10: Once granted, the request is not raised again until ready falls and rises again, or until the enable is cleared and set again.
- R11: While the enable is 0, the request drops on the next clock and is never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Register bus byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 2 | Byte-lane select; bit 0 is the low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| baud_slow | input | 1 | Selects the slower of the two bit rates |
| tx_line | output | 1 | Serial output, idle high |
| intr_req | output | 1 | Interrupt request |
| intr_grant | input | 1 | Interrupt grant |
| intr_ack | output | 1 | One-cycle acknowledge, returned after a grant |
| intr_vector | output | 8 | Vector, valid while intr_ack is high |

## Verification
The bench builds the block with CLK_HZ=96000, FAST_BAUD=9600 and SLOW_BAUD=4800. This makes each bit 10 or 20 clocks long, so a whole frame takes 100 to 200 cycles. With frames that short, the bench can measure the start-bit width exactly at both rates. It can also queue a second byte behind a frame in flight and watch ready stay low across the frame boundary. It can also set the enable during a busy frame and catch the request when that frame ends, all within a short run.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int RDY_BIT    = 7;
  localparam int IE_BIT     = 6;
  localparam int FRAME_BITS = 10;
  localparam int BCNT_W     = $clog2(FRAME_BITS + 1);

  function automatic int bit_div(input int clk_hz, input int baud);
    int d;
    d = clk_hz / baud;
    if (d < 2) d = 2;
    return d;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ser_tx_regs.sv
module ser_tx_regs #(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter logic [15:0] CSR_ADDR  = 16'o177564,
  parameter logic [15:0] DATA_ADDR = 16'o177566
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [1:0]    bus_be,
  input  logic [DW-1:0] bus_wdata,
  input  logic          ready,
  output logic          ie,
  output logic          data_wr,
  output logic [7:0]    data_byte,
  output logic [DW-1:0] bus_rdata
);
  import ser_tx_pkg::*;

  logic hit_csr, hit_data, csr_wr;
  logic unused_bits;

  assign hit_csr   = (bus_addr == AW'(CSR_ADDR));
  assign hit_data  = (bus_addr == AW'(DATA_ADDR));
  assign csr_wr    = bus_wr && hit_csr && bus_be[0];
  assign data_wr   = bus_wr && hit_data && bus_be[0];
  assign data_byte = bus_wdata[7:0];
  assign unused_bits = ^{bus_be[1], bus_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      ie <= 1'b0;
    end else if (csr_wr) begin
      ie <= bus_wdata[IE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd && hit_csr) begin
      bus_rdata <= '0;
      bus_rdata[RDY_BIT] <= ready;
      bus_rdata[IE_BIT]  <= ie;
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold (
  input  logic       clk,
  input  logic       rst,
  input  logic       data_wr,
  input  logic [7:0] data_byte,
  input  logic       sh_busy,
  output logic       hold_full,
  output logic [7:0] hold_byte,
  output logic       load,
  output logic       ready
);
  assign load  = hold_full && !sh_busy;
  assign ready = !hold_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_byte <= '0;
    end else if (data_wr) begin
      hold_full <= 1'b1;
      hold_byte <= data_byte;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 20,
  localparam int CW = $clog2(ser_tx_pkg::max2(DIV_FAST, DIV_SLOW) + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic slow_in,
  output logic tick
);
  logic [CW-1:0] cnt;
  logic          slow_q;
  logic [CW-1:0] last;

  assign last = slow_q ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
  assign tick = run && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      slow_q <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      slow_q <= slow_in;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ser_tx_shift.sv
module ser_tx_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       tick,
  output logic       busy,
  output logic       tx
);
  import ser_tx_pkg::*;

  logic [8:0]        sh;
  logic [BCNT_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tx   <= 1'b1;
      sh   <= '1;
      bcnt <= '0;
    end else if (load) begin
      busy <= 1'b1;
      tx   <= 1'b0;
      sh   <= {1'b1, load_byte};
      bcnt <= '0;
    end else if (busy && tick) begin
      if (bcnt == BCNT_W'(FRAME_BITS - 1)) begin
        busy <= 1'b0;
        tx   <= 1'b1;
      end else begin
        tx   <= sh[0];
        sh   <= {1'b1, sh[8:1]};
        bcnt <= bcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ser_tx_irq.sv
module ser_tx_irq #(
  parameter logic [7:0] VECTOR = 8'o064
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ready,
  input  logic       ie,
  input  logic       grant,
  output logic       req,
  output logic       ack,
  output logic [7:0] vector
);
  logic cond, cond_q;

  assign cond = ready && ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      req    <= 1'b0;
      ack    <= 1'b0;
      vector <= '0;
    end else begin
      cond_q <= cond;
      ack    <= grant && req;
      vector <= (grant && req) ? VECTOR : 8'h00;
      if (!ie)
        req <= 1'b0;
      else if (grant && req)
        req <= 1'b0;
      else if (cond && !cond_q)
        req <= 1'b1;
    end
  end
endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf #(
  parameter int          CLK_HZ    = 50_000_000,
  parameter int          FAST_BAUD = 9600,
  parameter int          SLOW_BAUD = 4800,
  parameter logic [15:0] CSR_ADDR  = 16'o177564,
  parameter logic [15:0] DATA_ADDR = 16'o177566,
  parameter logic [7:0]  VECTOR    = 8'o064,
  localparam int DIV_FAST = ser_tx_pkg::bit_div(CLK_HZ, FAST_BAUD),
  localparam int DIV_SLOW = ser_tx_pkg::bit_div(CLK_HZ, SLOW_BAUD)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        baud_slow,
  output logic        tx_line,
  output logic        intr_req,
  input  logic        intr_grant,
  output logic        intr_ack,
  output logic [7:0]  intr_vector
);
  logic       ie, data_wr, hold_full, load, ready, sh_busy, tick;
  logic [7:0] data_byte, hold_byte;

  ser_tx_regs #(.AW(16), .DW(16), .CSR_ADDR(CSR_ADDR), .DATA_ADDR(DATA_ADDR)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .ready(ready), .ie(ie),
    .data_wr(data_wr), .data_byte(data_byte), .bus_rdata(bus_rdata)
  );

  ser_tx_hold u_hold (
    .clk(clk), .rst(rst), .data_wr(data_wr), .data_byte(data_byte),
    .sh_busy(sh_busy), .hold_full(hold_full), .hold_byte(hold_byte),
    .load(load), .ready(ready)
  );

  ser_tx_baud #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_baud (
    .clk(clk), .rst(rst), .restart(load), .run(sh_busy),
    .slow_in(baud_slow), .tick(tick)
  );

  ser_tx_shift u_shift (
    .clk(clk), .rst(rst), .load(load), .load_byte(hold_byte),
    .tick(tick), .busy(sh_busy), .tx(tx_line)
  );

  ser_tx_irq #(.VECTOR(VECTOR)) u_irq (
    .clk(clk), .rst(rst), .ready(ready), .ie(ie), .grant(intr_grant),
    .req(intr_req), .ack(intr_ack), .vector(intr_vector)
  );
endmodule

// File: rtl/ser_tx_dbuf_chk.sv
module ser_tx_dbuf_chk #(
  parameter logic [7:0] VEC = 8'o064
) (
  input logic       clk,
  input logic       rst,
  input logic       tx_line,
  input logic       busy,
  input logic       hold_full,
  input logic       data_wr,
  input logic       ie,
  input logic       intr_req,
  input logic       intr_grant,
  input logic       intr_ack,
  input logic [7:0] intr_vector
);
  // R6
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_line);

  // R4
  handoff_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_full && !busy && !data_wr) |=> !hold_full);

  // R9
  vector_chk: assert property (@(posedge clk) disable iff (rst)
    intr_ack |-> (intr_vector == VEC));

  // R9
  ack_src_chk: assert property (@(posedge clk) disable iff (rst)
    intr_ack |-> ($past(intr_grant) && $past(intr_req)));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (intr_req && !intr_grant && ie) |=> intr_req);

  // R11
  ie_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !intr_req);

  // R8
  req_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(intr_req) |-> ($past(ie) && !$past(hold_full)));
endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk #(.VEC(VECTOR)) u_chk (
  .clk(clk), .rst(rst), .tx_line(tx_line), .busy(sh_busy),
  .hold_full(hold_full), .data_wr(data_wr), .ie(ie),
  .intr_req(intr_req), .intr_grant(intr_grant), .intr_ack(intr_ack),
  .intr_vector(intr_vector)
);

// File: tb/ser_tx_dbuf_test.sv
`timescale 1ns/1ps
module ser_tx_dbuf_test;
  localparam int CLK_HZ = 96000;
  localparam int FAST = 9600;
  localparam int SLOW = 4800;
  localparam int DF = CLK_HZ / FAST;
  localparam int DS = CLK_HZ / SLOW;
  localparam logic [15:0] CSR = 16'o177564;
  localparam logic [15:0] DAT = 16'o177566;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        baud_slow = 1'b0;
  logic        tx_line;
  logic        intr_req;
  logic        intr_grant = 1'b0;
  logic        intr_ack;
  logic [7:0]  intr_vector;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ser_tx_dbuf #(.CLK_HZ(CLK_HZ), .FAST_BAUD(FAST), .SLOW_BAUD(SLOW)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .baud_slow(baud_slow), .tx_line(tx_line), .intr_req(intr_req),
    .intr_grant(intr_grant), .intr_ack(intr_ack), .intr_vector(intr_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic wait_low();
    for (int i = 0; i < 5000; i++) begin
      if (tx_line === 1'b0) return;
      @(negedge clk);
    end
  endtask

  task automatic capture(input int div, output logic [7:0] b, output logic st0, output logic sp);
    wait_low();
    repeat (div / 2) @(negedge clk);
    st0 = tx_line;
    for (int k = 0; k < 8; k++) begin
      repeat (div) @(negedge clk);
      b[k] = tx_line;
    end
    repeat (div) @(negedge clk);
    sp = tx_line;
  endtask

  task automatic settle();
    repeat (12 * DS) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 tx idle", tx_line, 1);
    chk("R1 req", intr_req, 0);
    chk("R1 ack", intr_ack, 0);
    rd(CSR, d); chk("R1/R2 csr", d, 16'h0080);
    rd(DAT, d); chk("R2 data reads 0", d, 0);
  endtask

  task automatic t_csr_write();
    logic [15:0] d;
    wr(CSR, 16'hFFBF, 2'b11); rd(CSR, d); chk("R3 other bits", d, 16'h0080);
    wr(CSR, 16'h0040, 2'b10); rd(CSR, d); chk("R3 lane0 off", d, 16'h0080);
    wr(CSR, 16'h0040, 2'b01); rd(CSR, d); chk("R3 ie set", d, 16'h00C0);
    wr(CSR, 16'h0000, 2'b11); rd(CSR, d); chk("R3 clear", d, 16'h0080);
    @(negedge clk);
    chk("R11 req gone", intr_req, 0);
  endtask

  task automatic t_handoff();
    logic [15:0] d; logic [7:0] b; logic s0, s1;
    wr(DAT, 16'h0055, 2'b01);
    rd(CSR, d); chk("R4 ready low", d, 16'h0000);
    rd(CSR, d); chk("R4 ready back", d, 16'h0080);
    capture(DF, b, s0, s1);
    chk("R6 start", s0, 0); chk("R6 byte", b, 8'h55); chk("R6 stop", s1, 1);
    settle();
    chk("R6 idle high", tx_line, 1);
  endtask

  task automatic t_busy_hold();
    logic [15:0] d; logic [7:0] b; logic s0, s1;
    wr(DAT, 16'h00A3, 2'b01);
    wr(DAT, 16'h003C, 2'b01);
    rd(CSR, d); chk("R5 ready low", d, 16'h0000);
    capture(DF, b, s0, s1); chk("R5 first byte", b, 8'hA3);
    rd(CSR, d); chk("R5 still low at stop", d, 16'h0000);
    capture(DF, b, s0, s1); chk("R5 second byte", b, 8'h3C);
    chk("R6 start2", s0, 0); chk("R6 stop2", s1, 1);
    rd(CSR, d); chk("R5 ready after", d, 16'h0080);
    settle();
  endtask

  task automatic t_rate(input logic slow, input int exp_len);
    int n;
    baud_slow = slow;
    wr(DAT, 16'h0001, 2'b01);
    wait_low();
    n = 0;
    while (tx_line === 1'b0 && n < 1000) begin
      n++; @(negedge clk);
    end
    chk(slow ? "R7 slow bit" : "R7 fast bit", n, exp_len);
    settle();
    baud_slow = 1'b0;
  endtask

  task automatic t_irq_ready();
    wr(CSR, 16'h0040, 2'b01);
    @(negedge clk); chk("R8 req after ie", intr_req, 1);
    repeat (5) @(negedge clk); chk("R9 req held", intr_req, 1);
    intr_grant = 1'b1;
    @(negedge clk);
    intr_grant = 1'b0;
    chk("R9 ack", intr_ack, 1);
    chk("R9 vector", intr_vector, 8'o064);
    chk("R9 req drop", intr_req, 0);
    @(negedge clk); chk("R9 ack pulse", intr_ack, 0);
    repeat (20) @(negedge clk); chk("R10 no rearm", intr_req, 0);
    wr(DAT, 16'h0011, 2'b01);
    repeat (3) @(negedge clk); chk("R10 rearm by ready", intr_req, 1);
    intr_grant = 1'b1; @(negedge clk); intr_grant = 1'b0;
    settle();
    chk("R10 quiet after frame", intr_req, 0);
    wr(CSR, 16'h0000, 2'b01);
    wr(CSR, 16'h0040, 2'b01);
    @(negedge clk); chk("R10 rearm by ie", intr_req, 1);
    wr(CSR, 16'h0000, 2'b01);
    @(negedge clk); chk("R11 drop on clear", intr_req, 0);
    wr(DAT, 16'h0022, 2'b01);
    repeat (5) @(negedge clk); chk("R11 no req disabled", intr_req, 0);
    settle();
  endtask

  task automatic t_irq_busy();
    wr(DAT, 16'h0077, 2'b01);
    wr(DAT, 16'h0088, 2'b01);
    wr(CSR, 16'h0040, 2'b01);
    repeat (3) @(negedge clk); chk("R8 no req while busy", intr_req, 0);
    repeat (10 * DF + 6) @(negedge clk); chk("R8 req at handoff", intr_req, 1);
    intr_grant = 1'b1; @(negedge clk); intr_grant = 1'b0;
    chk("R9 ack busy case", intr_ack, 1);
    wr(CSR, 16'h0000, 2'b01);
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_csr_write();
    t_handoff();
    t_busy_hold();
    t_rate(1'b0, DF);
    t_rate(1'b1, DS);
    t_irq_ready();
    t_irq_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule